// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-facing register bank of a serial port. A host reaches it over a plain 32-bit word bus with a request strobe, a write flag, a byte address and four byte enables. Read data comes back one cycle after the request, together with a response-valid pulse. Baud-rate generation and line serialisation happen elsewhere. On the line side, the block takes received bytes on a valid/data pair and queues them in a 16-entry receive FIFO. When software writes the transmit-data word, the block presents the low byte on a one-cycle strobe.

Software sees the queue through two status/data words. Both return the oldest byte together with a data-available flag and two transmitter flags that always read as 1. One word only looks at the byte. The other also pops it. The interrupt side has a raw register, a mask, an acknowledge register and a masked view, and these drive one level interrupt output. A transmit write raises two raw bits and arms a pending flag. The first acknowledge after that write cannot clear bit 0.

Two small state machines are involved. The response machine has the states RSP_IDLE and RSP_DATA. It moves to RSP_DATA on every read request and returns to RSP_IDLE after a cycle with no read. The transmit-pending machine has the states TXP_CLEAR and TXP_ARMED. A transmit write moves it from TXP_CLEAR to TXP_ARMED. An acknowledge write moves it from TXP_ARMED back to TXP_CLEAR. It holds its state otherwise.

Top module: `sport_regfile`

## Requirements
- R1: After reset, the receive control word (byte offset 0x08) reads 0x0001_0000, every other stored word reads 0, the FIFO is empty and irq is low.
- R2: An access acts only if all four byte enables are set, address bits 1:0 are 0 and the address is below 0x3C. Any other access changes nothing. Every read request gets rsp_valid one cycle later, with data 0 for an access that does not act.
- R3: A read at 0x20 or 0x24 returns the oldest queued byte in bits 7:0, bit 16 set when the FIFO is not empty, and bits 22 and 24 always 1. All other bits are 0. Bits 7:0 are undefined when the FIFO is empty.
- R4: A read at 0x20 removes the oldest byte if one is queued. A read at 0x24 removes nothing.
- R5: The FIFO holds 16 bytes in arrival order. A byte that arrives while 16 are held is dropped.
- R6: A received byte is accepted only while bit 3 of the receive control word is 1.
- R7: A write to 0x1C drives tx_stb high for exactly the next cycle with tx_byte equal to written bits 7:0. It sets raw interrupt bits 0 and 1 and arms the transmit-pending state.
- R8: A write to 0x30 clears each raw interrupt bit whose written bit is 1. If transmit-pending is armed, bit 0 is first removed from the value and the state disarms. Reading 0x30 returns the value after that change.
- R9: Raw interrupt bit 3 (read at 0x34) takes the FIFO-not-empty value after every acting bus write and after every accepted byte. A pop read alone leaves it unchanged.
- R10: The masked word (0x38) equals the raw word AND the mask word (0x2C). irq is high exactly when that result is non-zero.
- R11: Acting writes to 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C and 0x2C read back as written. Writes to 0x20, 0x24, 0x34 and 0x38 change no stored state.
- R12: A byte accepted in the same cycle as a pop leaves the FIFO count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Bus access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_be | input | 4 | Byte enables, all four required |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| rx_valid | input | 1 | Received byte present |
| rx_byte | input | 8 | Received byte |
| tx_stb | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Byte to transmit, valid with tx_stb |
| irq | output | 1 | Level interrupt request |

## Verification
Read data and rsp_valid are due one cycle after the request. tx_stb and tx_byte are due one cycle after the transmit write. irq and every register effect of a write or received byte show up in the first read or irq sample after the capturing edge. The bench drives inputs on the falling edge and advances its reference model at that moment. It compares every output on the next falling edge, so each result is checked in exactly the cycle it is due. Random traffic runs alongside directed cases for a full queue, a disabled receiver, a push and pop in one cycle, the stale raw bit 3 after a pop, and the acknowledge fix-up.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int DATA_W     = 32;
    localparam int IDX_W      = 4;
    localparam int WORD_SLOTS = 1 << IDX_W;
    localparam int NUM_WORDS  = 15;

    // word indices (byte offset / 4)
    localparam int OFS_TXCTL  = 0;
    localparam int OFS_TXDMA  = 1;
    localparam int OFS_RXCTL  = 2;
    localparam int OFS_TXDATA = 7;
    localparam int OFS_POP    = 8;
    localparam int OFS_PEEK   = 9;
    localparam int OFS_MASK   = 11;
    localparam int OFS_ACK    = 12;
    localparam int OFS_RAW    = 13;
    localparam int OFS_MSKD   = 14;

    // status word flags
    localparam int ST_DAV  = 16;
    localparam int ST_IDLE = 22;
    localparam int ST_RDY  = 24;

    localparam int RXEN_BIT = 3;
    localparam logic [DATA_W-1:0] RXCTL_RST = 32'h0001_0000;

    // raw interrupt bits
    localparam int IRQ_TXA  = 0;
    localparam int IRQ_TXB  = 1;
    localparam int IRQ_RXNE = 3;

    typedef enum logic { TXP_CLEAR, TXP_ARMED } txp_state_t;
    typedef enum logic { RSP_IDLE,  RSP_DATA  } rsp_state_t;

    function automatic bit word_is_stored(input int idx);
        return (idx < NUM_WORDS) && (idx != OFS_POP) && (idx != OFS_PEEK) &&
               (idx != OFS_RAW) && (idx != OFS_MSKD);
    endfunction

    function automatic logic [DATA_W-1:0] word_reset(input int idx);
        return (idx == OFS_RXCTL) ? RXCTL_RST : '0;
    endfunction

endpackage

// File: rtl/sport_rxq.sv
module sport_rxq #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_req,
    input  logic [WIDTH-1:0]              push_data,
    input  logic                          pop_req,
    output logic [WIDTH-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic [$clog2(DEPTH+1)-1:0]    count_nxt,
    output logic                          push_ok,
    output logic                          pop_ok
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    assign push_ok = push_req && (count != CNT_FULL);
    assign pop_ok  = pop_req  && (count != '0);
    assign head    = mem[rd_ptr];

    always_comb begin
        unique case ({push_ok, pop_ok})
            2'b10:   count_nxt = count + 1'b1;
            2'b01:   count_nxt = count - 1'b1;
            default: count_nxt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            count <= count_nxt;
        end
    end
endmodule

// File: rtl/sport_txp.sv
module sport_txp #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr,
    input  logic              ack_wr,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              armed,
    output logic              tx_stb,
    output logic [BYTE_W-1:0] tx_byte
);
    import sport_pkg::*;

    txp_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            TXP_CLEAR: if (tx_wr)  state_nxt = TXP_ARMED;
            TXP_ARMED: if (ack_wr) state_nxt = TXP_CLEAR;
            default:   state_nxt = TXP_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXP_CLEAR;
        else        state <= state_nxt;
    end

    // output process: registered strobe and byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_stb  <= 1'b0;
            tx_byte <= '0;
        end else begin
            tx_stb <= tx_wr;
            if (tx_wr) tx_byte <= tx_data;
        end
    end

    assign armed = (state == TXP_ARMED);
endmodule

// File: rtl/sport_rsp.sv
module sport_rsp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    import sport_pkg::*;

    rsp_state_t state, state_nxt;

    always_comb begin
        unique case (state)
            RSP_IDLE: state_nxt = rd_req ? RSP_DATA : RSP_IDLE;
            RSP_DATA: state_nxt = rd_req ? RSP_DATA : RSP_IDLE;
            default:  state_nxt = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RSP_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (rd_req) rsp_rdata <= rd_word;
    end

    assign rsp_valid = (state == RSP_DATA);
endmodule

// File: rtl/sport_regfile.sv
module sport_regfile #(
    parameter int ADDR_W    = 8,
    parameter int RXQ_DEPTH = 16,
    parameter int BYTE_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_req,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [3:0]                  bus_be,
    input  logic [sport_pkg::DATA_W-1:0] bus_wdata,
    output logic                        rsp_valid,
    output logic [sport_pkg::DATA_W-1:0] rsp_rdata,
    input  logic                        rx_valid,
    input  logic [BYTE_W-1:0]           rx_byte,
    output logic                        tx_stb,
    output logic [BYTE_W-1:0]           tx_byte,
    output logic                        irq
);
    import sport_pkg::*;

    localparam int CNT_W = $clog2(RXQ_DEPTH + 1);
    localparam int WADR_W = ADDR_W - 2;

    // ---------------- decode ----------------
    logic [WADR_W-1:0] word_adr;
    logic [IDX_W-1:0]  idx;
    logic              acc_ok, wr_fire, rd_fire, rd_any;

    assign word_adr = bus_addr[ADDR_W-1:2];
    assign idx      = word_adr[IDX_W-1:0];
    assign acc_ok   = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00) &&
                      (word_adr < WADR_W'(NUM_WORDS));
    assign wr_fire  = bus_req &&  bus_we && acc_ok;
    assign rd_any   = bus_req && !bus_we;
    assign rd_fire  = rd_any && acc_ok;

    logic tx_wr, ack_wr, pop_rd;
    assign tx_wr  = wr_fire && (idx == IDX_W'(OFS_TXDATA));
    assign ack_wr = wr_fire && (idx == IDX_W'(OFS_ACK));
    assign pop_rd = rd_fire && (idx == IDX_W'(OFS_POP));

    // ---------------- transmit pending ----------------
    logic txp_armed;
    sport_txp #(.BYTE_W(BYTE_W)) u_txp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_wr   (tx_wr),
        .ack_wr  (ack_wr),
        .tx_data (bus_wdata[BYTE_W-1:0]),
        .armed   (txp_armed),
        .tx_stb  (tx_stb),
        .tx_byte (tx_byte)
    );

    logic [DATA_W-1:0] ack_fix;
    assign ack_fix = txp_armed ? (bus_wdata & ~(DATA_W'(1) << IRQ_TXA)) : bus_wdata;

    // ---------------- stored words ----------------
    logic [DATA_W-1:0] word_q [WORD_SLOTS];

    for (genvar g = 0; g < WORD_SLOTS; g++) begin : g_word
        if (word_is_stored(g)) begin : g_store
            localparam logic [DATA_W-1:0] RST_V = word_reset(g);
            logic [DATA_W-1:0] wval;
            assign wval = (g == OFS_ACK) ? ack_fix : bus_wdata;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    word_q[g] <= RST_V;
                else if (wr_fire && (idx == IDX_W'(g)))
                    word_q[g] <= wval;
            end
        end else begin : g_none
            assign word_q[g] = '0;
        end
    end

    logic rx_en;
    assign rx_en = word_q[OFS_RXCTL][RXEN_BIT];

    // ---------------- receive FIFO ----------------
    logic [BYTE_W-1:0] q_head;
    logic [CNT_W-1:0]  q_count, q_count_nxt;
    logic              q_push_ok, q_pop_ok;

    sport_rxq #(.DEPTH(RXQ_DEPTH), .WIDTH(BYTE_W)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (rx_valid && rx_en),
        .push_data (rx_byte),
        .pop_req   (pop_rd),
        .head      (q_head),
        .count     (q_count),
        .count_nxt (q_count_nxt),
        .push_ok   (q_push_ok),
        .pop_ok    (q_pop_ok)
    );

    // ---------------- interrupts ----------------
    logic [1:0] raw_tx;
    logic       raw_rxne;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_tx   <= '0;
            raw_rxne <= 1'b0;
        end else begin
            if (tx_wr)       raw_tx <= 2'b11;
            else if (ack_wr) raw_tx <= raw_tx & ~ack_fix[IRQ_TXB:IRQ_TXA];
            if (wr_fire || q_push_ok) raw_rxne <= (q_count_nxt != '0);
        end
    end

    logic [DATA_W-1:0] raw_word, masked_word, stat_word;

    always_comb begin
        raw_word = '0;
        raw_word[IRQ_TXB:IRQ_TXA] = raw_tx;
        raw_word[IRQ_RXNE] = raw_rxne;
    end

    assign masked_word = raw_word & word_q[OFS_MASK];
    assign irq         = |masked_word;

    always_comb begin
        stat_word = '0;
        stat_word[BYTE_W-1:0] = q_head;
        stat_word[ST_DAV]  = (q_count != '0);
        stat_word[ST_IDLE] = 1'b1;
        stat_word[ST_RDY]  = 1'b1;
    end

    // ---------------- read mux and response ----------------
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        if (!acc_ok)
            rd_word = '0;
        else if ((idx == IDX_W'(OFS_POP)) || (idx == IDX_W'(OFS_PEEK)))
            rd_word = stat_word;
        else if (idx == IDX_W'(OFS_RAW))
            rd_word = raw_word;
        else if (idx == IDX_W'(OFS_MSKD))
            rd_word = masked_word;
        else
            rd_word = word_q[idx];
    end

    sport_rsp #(.DATA_W(DATA_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_any),
        .rd_word   (rd_word),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/sport_regfile_chk.sv
module sport_regfile_chk #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_req,
    input logic                       bus_we,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [3:0]                 bus_be,
    input logic                       rsp_valid,
    input logic                       tx_stb,
    input logic                       rx_en,
    input logic [$clog2(DEPTH+1)-1:0] q_count,
    input logic                       q_push,
    input logic                       q_pop
);
    import sport_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic tx_hit, rd_hit;
    assign tx_hit = bus_req && bus_we && (bus_be == 4'hF) &&
                    (bus_addr == ADDR_W'(OFS_TXDATA * 4));
    assign rd_hit = bus_req && !bus_we;

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> rsp_valid);                                            // R2
    AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rd_hit));                                     // R2
    AST_TX_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hit |=> tx_stb);                                               // R7
    AST_TX_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |-> $past(tx_hit));                                        // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_FULL);                                             // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CNT_FULL && !q_pop) |=> (q_count == CNT_FULL));       // R5
    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (q_count <= $past(q_count)));                          // R6
    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push && q_pop) |=> (q_count == $past(q_count)));               // R12
endmodule

bind sport_regfile sport_regfile_chk #(.ADDR_W(ADDR_W), .DEPTH(RXQ_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .rsp_valid (rsp_valid),
    .tx_stb    (tx_stb),
    .rx_en     (rx_en),
    .q_count   (q_count),
    .q_push    (q_push_ok),
    .q_pop     (q_pop_ok)
);

// File: tb/sim_sport_regfile.sv
module sim_sport_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_stb;
    logic [7:0]  tx_byte;
    logic        irq;

    always #4 clk = ~clk;   // 125 MHz

    sport_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_stb(tx_stb), .tx_byte(tx_byte), .irq(irq)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_reg [15];
    logic [1:0]  m_rawtx;
    logic        m_rawne, m_pend;
    logic [7:0]  m_q [16];
    int          m_wp, m_rp, m_cnt;
    logic        e_rv, e_stb, e_lowok;
    logic [31:0] e_rd;
    logic [7:0]  e_tb;
    string       e_tag;
    logic [31:0] last_rd;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_raw();
        return {28'd0, m_rawne, 1'b0, m_rawtx};
    endfunction

    function automatic logic [31:0] m_read(input int i);
        logic [31:0] v;
        if (i == 8 || i == 9) begin
            v = 32'h0140_0000;
            if (m_cnt > 0) v = v | 32'h0001_0000 | {24'd0, m_q[m_rp]};
            return v;
        end
        if (i == 13) return m_raw();
        if (i == 14) return m_raw() & m_reg[11];
        return m_reg[i];
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 15; i++) m_reg[i] = '0;
        m_reg[2] = 32'h0001_0000;
        m_rawtx = '0; m_rawne = 0; m_pend = 0;
        m_wp = 0; m_rp = 0; m_cnt = 0;
    endtask

    task automatic m_step(input bit req, input bit we, input logic [7:0] a,
                          input logic [3:0] be, input logic [31:0] wd,
                          input bit rv, input logic [7:0] rb);
        bit ok, push, pop, wr;
        int i;
        logic [31:0] fx;
        i  = int'(a[7:2]);
        ok = (be == 4'hF) && (a[1:0] == 2'b00) && (i < 15);
        wr = req && we && ok;
        e_rv = req && !we;
        e_lowok = 1;
        e_rd = 0;
        e_tag = "R2";
        if (e_rv && ok) begin
            e_rd = m_read(i);
            if ((i == 8 || i == 9) && m_cnt == 0) e_lowok = 0;
            e_tag = (i == 8 || i == 9) ? "R3/R4" : (i == 13) ? "R9" :
                    (i == 14) ? "R10" : (i == 12) ? "R8" : "R11";
        end
        push = rv && m_reg[2][3] && (m_cnt < 16);
        pop  = e_rv && ok && (i == 8) && (m_cnt > 0);
        if (pop)  begin m_rp = (m_rp + 1) % 16; m_cnt--; end
        if (push) begin m_q[m_wp] = rb; m_wp = (m_wp + 1) % 16; m_cnt++; end
        e_stb = wr && (i == 7);
        if (e_stb) begin e_tb = wd[7:0]; m_rawtx = 2'b11; m_pend = 1; end
        if (wr && i == 12) begin
            fx = m_pend ? (wd & ~32'h1) : wd;
            m_pend = 0;
            m_rawtx = m_rawtx & ~fx[1:0];
            m_reg[12] = fx;
        end else if (wr && !(i == 8 || i == 9 || i == 13 || i == 14)) begin
            m_reg[i] = wd;
        end
        if (wr || push) m_rawne = (m_cnt != 0);
    endtask

    task automatic step(input bit req, input bit we, input logic [7:0] a,
                        input logic [3:0] be, input logic [31:0] wd,
                        input bit rv, input logic [7:0] rb);
        logic [31:0] msk;
        bus_req = req; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
        rx_valid = rv; rx_byte = rb;
        m_step(req, we, a, be, wd, rv, rb);
        @(posedge clk);
        @(negedge clk);
        bus_req = 0; rx_valid = 0;
        chk(rsp_valid == e_rv, "R2 rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rv});
        if (e_rv) begin
            msk = e_lowok ? 32'hFFFF_FFFF : 32'hFFFF_FF00;
            chk((rsp_rdata & msk) == (e_rd & msk), e_tag, rsp_rdata, e_rd);
            last_rd = rsp_rdata;
        end
        chk(tx_stb == e_stb, "R7 tx_stb", {31'd0, tx_stb}, {31'd0, e_stb});
        if (e_stb) chk(tx_byte == e_tb, "R7 tx_byte", {24'd0, tx_byte}, {24'd0, e_tb});
        chk(irq == (|(m_raw() & m_reg[11])), "R10 irq", {31'd0, irq},
            {31'd0, |(m_raw() & m_reg[11])});
    endtask

    task automatic rd(input logic [7:0] a);
        step(1, 0, a, 4'hF, 0, 0, 0);
    endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1, 1, a, 4'hF, d, 0, 0);
    endtask
    task automatic rx(input logic [7:0] b);
        step(0, 0, 0, 0, 0, 1, b);
    endtask

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        void'($urandom(32'd2718));
        @(negedge clk);

        // reset state
        chk(irq == 0, "R1 irq after reset", {31'd0, irq}, 0);
        rd(8'h08); chk(last_rd == 32'h0001_0000, "R1 rx control reset", last_rd, 32'h0001_0000);
        rd(8'h24); chk(last_rd[16] == 0, "R1 queue empty", last_rd, 32'h0140_0000);

        // receiver disabled
        rx(8'h11); rx(8'h12);
        rd(8'h24); chk(last_rd[16] == 0, "R6 disabled receiver", last_rd, 32'h0140_0000);

        // fill beyond depth
        wr(8'h08, 32'h0001_0008);
        for (int k = 0; k < 17; k++) rx(8'h40 + 8'(k));
        rd(8'h24); rd(8'h24);
        chk(last_rd == 32'h0141_0040, "R4 peek keeps head", last_rd, 32'h0141_0040);
        for (int k = 0; k < 16; k++) begin
            rd(8'h20);
            chk(last_rd[7:0] == 8'h40 + 8'(k), "R5 order", last_rd, {24'd0, 8'h40 + 8'(k)});
        end
        rd(8'h20); chk(last_rd[16] == 0, "R5 17th byte dropped", last_rd, 32'h0140_0000);

        // stale raw bit 3 after pop
        wr(8'h2C, 32'h8); chk(irq == 0, "R9 refresh on write", {31'd0, irq}, 0);
        rx(8'h77);        chk(irq == 1, "R9 set by byte", {31'd0, irq}, 1);
        rd(8'h20);        chk(irq == 1, "R9 pop leaves bit", {31'd0, irq}, 1);
        wr(8'h2C, 32'h8); chk(irq == 0, "R9 cleared by write", {31'd0, irq}, 0);

        // push and pop together
        rx(8'h01); rx(8'h02);
        step(1, 0, 8'h20, 4'hF, 0, 1, 8'h03);
        rd(8'h20); chk(last_rd[7:0] == 8'h02, "R12 second byte", last_rd, 32'h0141_0002);
        rd(8'h20); chk(last_rd[7:0] == 8'h03, "R12 third byte", last_rd, 32'h0141_0003);
        rd(8'h24); chk(last_rd[16] == 0, "R12 count held", last_rd, 32'h0140_0000);

        // transmit and acknowledge fix-up
        wr(8'h2C, 32'h3);
        wr(8'h1C, 32'h1234_56A5);
        rd(8'h34); chk(last_rd == 32'h3, "R7 raw bits", last_rd, 32'h3);
        wr(8'h30, 32'h3);
        rd(8'h34); chk(last_rd == 32'h1, "R8 bit0 kept", last_rd, 32'h1);
        rd(8'h30); chk(last_rd == 32'h2, "R8 fixed ack", last_rd, 32'h2);
        wr(8'h30, 32'h1);
        rd(8'h34); chk(last_rd == 32'h0, "R8 second ack", last_rd, 32'h0);
        rd(8'h38); chk(last_rd == 32'h0, "R10 masked", last_rd, 32'h0);

        // ignored writes and plain words
        wr(8'h34, 32'hFFFF_FFFF); wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h34); chk(last_rd == 32'h0, "R11 raw not writable", last_rd, 32'h0);
        wr(8'h10, 32'hCAFE_0001);
        rd(8'h10); chk(last_rd == 32'hCAFE_0001, "R11 readback", last_rd, 32'hCAFE_0001);

        // partial and misaligned accesses
        step(1, 1, 8'h00, 4'h3, 32'hDEAD_BEEF, 0, 0);
        rd(8'h00); chk(last_rd == 32'h0, "R2 partial write ignored", last_rd, 32'h0);
        rd(8'h12); chk(last_rd == 32'h0, "R2 misaligned read", last_rd, 32'h0);
        rd(8'h3C); chk(last_rd == 32'h0, "R2 out of range", last_rd, 32'h0);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic [7:0] a;
            logic [3:0] be;
            logic [31:0] d;
            bit rv;
            op = int'($urandom % 10);
            a  = 8'(($urandom % 16) * 4);
            be = 4'hF;
            if ($urandom % 16 == 0) be = 4'($urandom);
            if ($urandom % 20 == 0) a = a | 8'(1 + $urandom % 3);
            d  = $urandom;
            rv = ($urandom % 3 == 0);
            if (a == 8'h08 && $urandom % 4 != 0) d = d | 32'h8;
            case (op)
                0, 1, 2: step(0, 0, a, be, d, rv, 8'($urandom));
                3, 4, 5: step(1, 0, a, be, d, rv, 8'($urandom));
                6, 7:    step(1, 1, a, be, d, rv, 8'($urandom));
                8:       step(1, 1, 8'h1C, 4'hF, d, rv, 8'($urandom));
                default: step(1, 1, 8'h30, 4'hF, d, rv, 8'($urandom));
            endcase
        end

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule